// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for two-channel serial audio. An external source supplies a bit clock, a word clock, a left/right clock and a serial data line. The block turns these into parallel left and right samples in twos-complement form. A system clock that runs well above the bit rate samples all four external lines through a synchronizer. Capture events are taken from the synchronized bit clock. A polarity input picks which bit-clock edge captures data. The bit clock may stop between bits.

A two-bit format input selects one of four framings. Three of them start a channel slot at a change of the left/right clock and place the most significant bit at a fixed offset after it: 0, 1 or 16 bit clocks. The fourth starts each word at a rising edge of the word clock. A four-bit length code sets the word length from 4 to 16 bits. Short words are sign-extended to the full output width. After the right word completes, the block presents both samples together with a one-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and after it is released, left and right outputs are zero and valid is low until a right word completes.
- R2: Words arrive MSB first. With the polarity input low, data is captured on rising edges of the bit clock.
- R3: With the polarity input high, data is captured on falling edges of the bit clock.
- R4: Format 00: the MSB is the bit captured at the first capture edge that sees a changed left/right level.
- R5: Format 01: the MSB is the bit captured one bit clock after that first edge.
- R6: Format 10: the MSB is the bit captured 16 bit clocks after that first edge.
- R7: Format 11: a word starts with the bit captured at the first capture edge that sees the word clock high after it was low. The left/right level at that edge only names the channel, and its own changes start no word.
- R8: Length code 0 means 16 bits. Codes 1 to 3 mean 4 bits, and codes 4 to 15 mean that many bits. The received word is sign-extended from its top bit to 16 bits.
- R9: Data bits in a slot before the MSB position or after the last word bit do not affect the outputs.
- R10: Left/right high names the left channel. When the last bit of a right word is captured, left_o (the latest left word) and right_o update together, and valid_o is high for exactly one cycle. That cycle is the third system-clock edge after the bit-clock capture edge drives the input.
- R11: Pauses of any length in the bit clock between bits do not change the received words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock, used in format 11 |
| lrck_i | input | 1 | External left/right clock, high = left |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing select (00, 01, 10, 11) |
| bclk_inv_i | input | 1 | 0: capture on rising edge, 1: capture on falling edge |
| len_code_i | input | 4 | Word-length code |
| left_o | output | 16 | Left sample, sign-extended |
| right_o | output | 16 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Every result is due exactly three system-clock edges after the bench drives the bit-clock edge that captures a right word's last bit. Two of those edges are the synchronizer stages, and the third is the framer register. The bench records the cycle number at which it drives that edge. A monitor sampling on the falling system-clock edge records the cycle of each valid pulse and the values presented with it. Each frame is then checked for one pulse only, at the recorded cycle plus three, with the expected left and right values. The external lines change only on falling system-clock edges and stay stable for at least four cycles before a capture edge, so the expected cycle does not depend on process order.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ     = 2'b00,
    FMT_LJ_DLY = 2'b01,
    FMT_RJ     = 2'b10,
    FMT_WCLK   = 2'b11
  } fmt_e;

  typedef struct packed {
    logic bclk;
    logic wclk;
    logic lrck;
    logic sdat;
  } line_t;
endpackage

// File: rtl/asrx_sync.sv
module asrx_sync
  import asrx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  line_t raw_i,
  output line_t now_o,
  output line_t prev_o
);
  localparam int DEPTH = STAGES + 1;

  line_t pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= raw_i;
  end

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign now_o  = pipe[STAGES-1];
  assign prev_o = pipe[STAGES];
endmodule

// File: rtl/asrx_framer.sv
module asrx_framer
  import asrx_pkg::*;
#(
  parameter int W      = 16,
  parameter int CNT_W  = 6,
  parameter int RJ_OFS = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              sdat_i,
  input  logic              lrck_i,
  input  logic              wclk_i,
  input  logic [1:0]        fmt_i,
  input  logic [CODE_W-1:0] len_code_i,
  output logic [W-1:0]      left_o,
  output logic [W-1:0]      right_o,
  output logic              valid_o
);
  localparam int LEN_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [W-1:0] sext(input logic [W-1:0] v, input logic [LEN_W-1:0] n);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < int'(n)) ? v[i] : v[n - 1'b1];
    return r;
  endfunction

  logic [CNT_W-1:0] cnt, k_next, msb_pos, last_pos;
  logic [LEN_W-1:0] wlen;
  logic [W-1:0]     sh, sh_next, left_hold;
  logic             lr_prev, wc_prev, chan, chan_now, slot_start, in_word, word_end;

  always_comb begin
    if (len_code_i == '0)                   wlen = LEN_W'(W);
    else if (len_code_i < CODE_W'(4))       wlen = LEN_W'(4);
    else                                    wlen = LEN_W'(len_code_i);
    case (fmt_e'(fmt_i))
      FMT_LJ_DLY: msb_pos = CNT_W'(1);
      FMT_RJ:     msb_pos = CNT_W'(RJ_OFS);
      default:    msb_pos = '0;
    endcase
    slot_start = (fmt_e'(fmt_i) == FMT_WCLK) ? (wclk_i && !wc_prev) : (lrck_i != lr_prev);
    if (slot_start)            k_next = '0;
    else if (cnt == CNT_MAX)   k_next = CNT_MAX;
    else                       k_next = cnt + 1'b1;
    chan_now = slot_start ? lrck_i : chan;
    last_pos = msb_pos + CNT_W'(wlen) - 1'b1;
    in_word  = (k_next >= msb_pos) && (k_next <= last_pos) && (k_next != CNT_MAX);
    word_end = in_word && (k_next == last_pos);
    sh_next  = {sh[W-2:0], sdat_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CNT_MAX;
      lr_prev   <= 1'b0;
      wc_prev   <= 1'b0;
      chan      <= 1'b0;
      sh        <= '0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        cnt     <= k_next;
        lr_prev <= lrck_i;
        wc_prev <= wclk_i;
        chan    <= chan_now;
        if (in_word) sh <= sh_next;
        if (word_end) begin
          if (chan_now) left_hold <= sext(sh_next, wlen);
          else begin
            left_o  <= left_hold;
            right_o <= sext(sh_next, wlen);
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  a_r10_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  a_r10_valid_follows_capture: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(cap_i));
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !(cap_i && slot_start)) |=> cnt == CNT_MAX);
  a_r8_right_sign_extended: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> right_o == sext(right_o, $past(wlen)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import asrx_pkg::*;
#(
  parameter int W           = 16,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6,
  parameter int RJ_OFS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  input  logic              bclk_inv_i,
  input  logic [CODE_W-1:0] len_code_i,
  output logic [W-1:0]      left_o,
  output logic [W-1:0]      right_o,
  output logic              valid_o
);
  line_t raw, now_l, prev_l;
  logic  cap;

  assign raw = '{bclk: bclk_i, wclk: wclk_i, lrck: lrck_i, sdat: sdata_i};

  asrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .raw_i(raw), .now_o(now_l), .prev_o(prev_l)
  );

  assign cap = (now_l.bclk != prev_l.bclk) && (now_l.bclk != bclk_inv_i);

  asrx_framer #(.W(W), .CNT_W(CNT_W), .RJ_OFS(RJ_OFS), .CODE_W(CODE_W)) framer_i (
    .clk(clk), .rst(rst), .cap_i(cap), .sdat_i(now_l.sdat), .lrck_i(now_l.lrck),
    .wclk_i(now_l.wclk), .fmt_i(fmt_i), .len_code_i(len_code_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  a_r2_capture_spacing: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);
endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WC_OFS = 2;

  logic clk = 0, rst = 1;
  logic bclk = 0, wclk = 0, lrck = 0, sdat = 0, inv = 0;
  logic [1:0] fmt = 0;
  logic [3:0] code = 0;
  logic [15:0] left, right;
  logic valid;

  int cyc = 0, nchk = 0, nfail = 0;
  int vcnt = 0, vcyc = 0, tcap = 0;
  logic [15:0] capl = 0, capr = 0;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk), .wclk_i(wclk), .lrck_i(lrck), .sdata_i(sdat),
    .fmt_i(fmt), .bclk_inv_i(inv), .len_code_i(code),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && valid) begin
    vcnt++; vcyc = cyc; capl = left; capr = right;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic iv, input logic [3:0] c);
    @(negedge clk);
    rst = 1; fmt = f; inv = iv; code = c; bclk = iv; lrck = 0; wclk = 0; sdat = 0;
    repeat (4) @(negedge clk);
    check("R1 left", left, 0); check("R1 right", right, 0); check("R1 valid", valid, 0);
    rst = 0; vcnt = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_bit(input logic d, input logic lr, input logic wc, input int gap, input bit last);
    sdat = d; lrck = lr; wclk = wc; bclk = inv;
    repeat (4 + gap) @(negedge clk);
    bclk = ~inv;
    if (last) tcap = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input string req, input int mode, input int len,
                            input logic [15:0] lw, input logic [15:0] rw, input int gap,
                            input logic [15:0] exl, input logic [15:0] exr);
    int ws;
    ws = (mode == 3) ? WC_OFS : (mode == 2) ? 16 : (mode == 1) ? 1 : 0;
    vcnt = 0;
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 32; k++) begin
        logic [15:0] w;
        logic d;
        w = (s == 0) ? lw : rw;
        d = (k >= ws && k < ws + len) ? w[len - 1 - (k - ws)] : 1'b1;
        drive_bit(d, (s == 0), (mode == 3 && k == ws), gap, (s == 1 && k == ws + len - 1));
      end
    end
    repeat (6) @(negedge clk);
    check({req, " pulses"}, vcnt, 1);
    check({req, " left"}, capl, exl);
    check({req, " right"}, capr, exr);
    check({req, " R10 latency"}, vcyc, tcap + 3);
  endtask

  task automatic t_lj;      do_reset(2'b00, 0, 4'd0); send_frame("R4 R2 R10", 0, 16, 16'h1234, 16'hBEEF, 0, 16'h1234, 16'hBEEF); endtask
  task automatic t_lj_dly;  do_reset(2'b01, 0, 4'd0); send_frame("R5", 1, 16, 16'hA5C3, 16'h0F0F, 0, 16'hA5C3, 16'h0F0F); endtask
  task automatic t_rj;      do_reset(2'b10, 0, 4'd0); send_frame("R6", 2, 16, 16'h8001, 16'h7FFE, 0, 16'h8001, 16'h7FFE); endtask
  task automatic t_rj12;    do_reset(2'b10, 0, 4'd12); send_frame("R6 R8", 2, 12, 16'h09AB, 16'h0123, 0, 16'hF9AB, 16'h0123); endtask
  task automatic t_wclk;    do_reset(2'b11, 0, 4'd0); send_frame("R7", 3, 16, 16'h4321, 16'hCAFE, 0, 16'h4321, 16'hCAFE); endtask
  task automatic t_inv;     do_reset(2'b00, 1, 4'd0); send_frame("R3", 0, 16, 16'h5AA5, 16'h9669, 0, 16'h5AA5, 16'h9669); endtask
  task automatic t_len4;    do_reset(2'b00, 0, 4'd4); send_frame("R8 R9", 0, 4, 16'h0009, 16'h0005, 0, 16'hFFF9, 16'h0005); endtask
  task automatic t_len_low; do_reset(2'b01, 0, 4'd2); send_frame("R8 R9", 1, 4, 16'h0003, 16'h000C, 0, 16'h0003, 16'hFFFC); endtask
  task automatic t_len8;    do_reset(2'b00, 0, 4'd8); send_frame("R8 R9", 0, 8, 16'h007F, 16'h0080, 0, 16'h007F, 16'hFF80); endtask
  task automatic t_burst;   do_reset(2'b01, 0, 4'd0); send_frame("R11", 1, 16, 16'hD00D, 16'h1EE7, 15, 16'hD00D, 16'h1EE7); endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_lj; t_lj_dly; t_rj; t_rj12; t_wclk; t_inv; t_len4; t_len_low; t_len8; t_burst;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule